// File: doc/BRIEF.md
# General-Purpose I/O Port with Atomic Set and Clear

This block is a parameterized general-purpose I/O port, 32 pins wide by default. Every pin has a direction bit and an output latch bit. Software never writes the output latch as a whole word. It raises bits through a write-one-to-set register and lowers bits through a write-one-to-clear register. As a result, two pieces of code can each change their own pins without a read-modify-write race.

The pad-side input vector passes through a flop synchronizer before software can read it. The status register always shows the synchronized pad level, whatever the direction of each pin. The output-value vector always carries the latch. The output-enable vector carries the direction register.

Access uses a simple register bus. A write strobe is qualified by a two-bit register address. Read data is combinational from the address.

Top module: `gpio_port`

## Requirements
- R1: After reset, the direction register and the output latch are all zero, so both pad_oe and pad_out are zero.
- R2: A write to address 0 (direction) loads the whole word. From the following cycle, pad_oe equals that word, and a read of address 0 returns it. A bit value of 1 marks an output and 0 marks an input.
- R3: A write to address 1 (set) drives high every latch bit whose data bit is 1. Latch bits whose data bit is 0 keep their value. pad_out shows the result from the following cycle.
- R4: A write to address 2 (clear) drives low every latch bit whose data bit is 1. Latch bits whose data bit is 0 keep their value.
- R5: A read of address 1 returns the output latch. A read of address 2 always returns zero.
- R6: A read of address 3 (pin status) returns pad_in as it was two clock edges earlier (two-stage synchronizer). This holds for every pin, input or output.
- R7: A write to address 3 changes neither the direction register nor the output latch.
- R8: pad_out carries the latch regardless of direction. Changing the direction never alters the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 direction, 1 set, 2 clear, 3 status |
| reg_wdata | input | WIDTH | Write data |
| reg_rdata | output | WIDTH | Read data for reg_addr |
| pad_in | input | WIDTH | Pad input levels (asynchronous) |
| pad_out | output | WIDTH | Output latch value to pads |
| pad_oe | output | WIDTH | Per-pin output enable |

## Verification
The hardest case to reach is a set or clear write that meets a latch which already holds a mixed pattern. Only then does the rule that zero data bits leave their latch bits alone become observable. The stimulus interleaves random set and clear words many times, so the latch wanders through many mixed states before each write. The pad inputs change every few operations, and status reads fall both one and two edges after a change, which tests the two-cycle lag against a bench copy of the delay line.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   localparam int GP_ADDR_W = 2;

   typedef enum logic [GP_ADDR_W-1:0] {
      GP_REG_DIR = 2'd0,
      GP_REG_SET = 2'd1,
      GP_REG_CLR = 2'd2,
      GP_REG_PIN = 2'd3
   } gp_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) stg[i] <= '0;
         else        stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_outreg.sv
module gpio_outreg #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_dir,
   input  logic             wr_set,
   input  logic             wr_clr,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] lat_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)      dir_q <= '0;
      else if (wr_dir) dir_q <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      lat_q <= '0;
      else if (wr_set) lat_q <= lat_q | wdata;
      else if (wr_clr) lat_q <= lat_q & ~wdata;
   end
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
   import gpio_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  gp_reg_e          sel,
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] lat_q,
   input  logic [WIDTH-1:0] pin_q,
   output logic [WIDTH-1:0] rdata
);
   always_comb begin
      unique case (sel)
         GP_REG_DIR: rdata = dir_q;
         GP_REG_SET: rdata = lat_q;
         GP_REG_CLR: rdata = '0;
         GP_REG_PIN: rdata = pin_q;
         default:    rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_pkg::*;
#(
   parameter int WIDTH       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr_en,
   input  logic [GP_ADDR_W-1:0] reg_addr,
   input  logic [WIDTH-1:0]     reg_wdata,
   output logic [WIDTH-1:0]     reg_rdata,
   input  logic [WIDTH-1:0]     pad_in,
   output logic [WIDTH-1:0]     pad_out,
   output logic [WIDTH-1:0]     pad_oe
);
   if (WIDTH < 1 || WIDTH > 64) begin : g_bad_width
      $error("gpio_port: WIDTH must be 1..64");
   end
   if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("gpio_port: SYNC_STAGES must be 2..4");
   end

   gp_reg_e          sel;
   logic             wr_dir, wr_set, wr_clr;
   logic [WIDTH-1:0] dir_q, lat_q, pin_q;

   assign sel    = gp_reg_e'(reg_addr);
   assign wr_dir = reg_wr_en && (sel == GP_REG_DIR);
   assign wr_set = reg_wr_en && (sel == GP_REG_SET);
   assign wr_clr = reg_wr_en && (sel == GP_REG_CLR);

   gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pin_q)
   );

   gpio_outreg #(.WIDTH(WIDTH)) u_outreg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_dir (wr_dir),
      .wr_set (wr_set),
      .wr_clr (wr_clr),
      .wdata  (reg_wdata),
      .dir_q  (dir_q),
      .lat_q  (lat_q)
   );

   gpio_rdmux #(.WIDTH(WIDTH)) u_rdmux (
      .sel   (sel),
      .dir_q (dir_q),
      .lat_q (lat_q),
      .pin_q (pin_q),
      .rdata (reg_rdata)
   );

   assign pad_out = lat_q;
   assign pad_oe  = dir_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
   parameter int WIDTH       = 32,
   parameter int SYNC_STAGES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr_en,
   input logic [1:0]       reg_addr,
   input logic [WIDTH-1:0] reg_wdata,
   input logic [WIDTH-1:0] reg_rdata,
   input logic [WIDTH-1:0] pad_in,
   input logic [WIDTH-1:0] pad_out,
   input logic [WIDTH-1:0] pad_oe
);
   logic [1:0] since_rst;
   logic       rst_q;

   always_ff @(posedge clk) begin
      rst_q <= rst_n;
      if (!rst_n)              since_rst <= '0;
      else if (since_rst != 3) since_rst <= since_rst + 2'd1;
   end

   always_ff @(posedge clk) begin
      if (rst_n && !rst_q)
         AST_RESET_IDLE: assert (pad_oe == '0 && pad_out == '0); // R1
   end

   AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_addr == 2'd0) |=> (pad_oe == $past(reg_wdata))); // R2
   AST_SET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_addr == 2'd1) |=> ((pad_out & $past(reg_wdata)) == $past(reg_wdata))); // R3
   AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_addr == 2'd1) |=>
      ((pad_out & ~$past(reg_wdata)) == ($past(pad_out) & ~$past(reg_wdata)))); // R3
   AST_CLR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_addr == 2'd2) |=> ((pad_out & $past(reg_wdata)) == '0)); // R4
   AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 2'd2) |-> (reg_rdata == '0)); // R5
   AST_PIN_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_addr == 2'd3) |=> ($stable(pad_out) && $stable(pad_oe))); // R7
   AST_DIR_KEEPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_addr == 2'd0) |=> $stable(pad_out)); // R8

   if (SYNC_STAGES == 2) begin : g_lag
      AST_PIN_LAG: assert property (@(posedge clk) disable iff (!rst_n)
         (since_rst == 3 && reg_addr == 2'd3) |-> (reg_rdata == $past(pad_in, 2))); // R6
   end
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr_en (reg_wr_en),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .pad_in    (pad_in),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe)
);

// File: tb/gpio_port_tb_top.sv
module gpio_port_tb_top;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_wr_en = 1'b0;
   logic [1:0]   reg_addr = 2'd0;
   logic [W-1:0] reg_wdata = '0;
   logic [W-1:0] reg_rdata;
   logic [W-1:0] pad_in = '0;
   logic [W-1:0] pad_out;
   logic [W-1:0] pad_oe;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   logic [W-1:0] m_dir = '0, m_lat = '0, m_s1 = '0, m_s2 = '0;

   always #5 clk = ~clk;

   gpio_port #(.WIDTH(W), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe)
   );

   // Two-stage delay model of the pin status path (R6)
   always @(posedge clk) begin
      if (!rst_n) begin m_s1 <= '0; m_s2 <= '0; end
      else begin m_s1 <= pad_in; m_s2 <= m_s1; end
   end

   function automatic logic [W-1:0] exp_read(input logic [1:0] a);
      case (a)
         2'd0:    return m_dir;
         2'd1:    return m_lat;
         2'd2:    return '0;
         default: return m_s2;
      endcase
   endfunction

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [1:0] a, input logic [W-1:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      case (a)
         2'd0: m_dir = d;
         2'd1: m_lat = m_lat | d;
         2'd2: m_lat = m_lat & ~d;
         default: ;
      endcase
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic check_outs(input string req);
      chk({req, " pad_out"}, pad_out, m_lat);
      chk({req, " pad_oe"}, pad_oe, m_dir);
   endtask

   task automatic do_read(input logic [1:0] a, input string req);
      reg_addr = a;
      #1;
      chk(req, reg_rdata, exp_read(a));
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      pad_in = 32'hA5A5_0F0F;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check_outs("R1 reset");
      @(negedge clk);

      do_write(2'd1, 32'hFFFF_FFFF); check_outs("R3 set all");
      do_read(2'd1, "R5 set readback");
      do_write(2'd2, 32'hAAAA_AAAA); check_outs("R4 clear alternate");
      do_write(2'd2, 32'h0000_0000); check_outs("R4 clear zero word");
      do_write(2'd1, 32'h0000_0000); check_outs("R3 set zero word");
      do_read(2'd2, "R5 clear reads zero");
      do_write(2'd0, 32'hF0F0_1234); check_outs("R2 dir write");
      do_read(2'd0, "R2 dir readback");
      chk("R8 latch kept on dir change", pad_out, 32'h5555_5555);
      do_write(2'd3, 32'hFFFF_FFFF); check_outs("R7 status write ignored");
      do_write(2'd0, 32'h0000_0000); check_outs("R8 dir cleared");

      // Pin lag, directed: one edge after a change the old value remains (R6)
      @(negedge clk);
      pad_in = 32'h1357_9BDF;
      @(negedge clk); do_read(2'd3, "R6 lag one edge");
      chk("R6 not yet visible", reg_rdata, 32'hA5A5_0F0F);
      @(negedge clk); do_read(2'd3, "R6 lag two edges");
      chk("R6 visible after two", reg_rdata, 32'h1357_9BDF);

      // Constrained random mix
      for (int i = 0; i < 600; i++) begin
         int op = $urandom % 6;
         logic [W-1:0] d = $urandom;
         if (op == 5) begin
            @(negedge clk);
            pad_in = $urandom;
            do_read(2'd3, "R6 random pin read");
         end else if (op == 4) begin
            do_read(2'($urandom % 4), "R5 R6 random read");
         end else begin
            do_write(2'(op), d);
            check_outs("R2 R3 R4 R7 R8 random write");
         end
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule